// File: doc/BRIEF.md
# IR Wake Pattern Matcher

This block watches the stream of already-demodulated IR cells coming from a remote-control front end and decides, at the end of each message, whether the message equals a stored wake pattern. Cells are written into an 88-bit capture register in arrival order. At message end the capture is compared with an 11-byte compare array. An 11-byte mask array picks the bit positions that take part, and a length register limits the comparison to the first N cells. A successful comparison sets a sticky flag and, if its event is enabled, raises the wake output.

Software programs the block through a small byte-wide register file. The two 11-byte arrays are not mapped directly. They are reached through an index register, which selects the array and the starting byte, and a data register whose address steps forward on every access. A whole array therefore loads with one index write followed by a burst of data writes. Status flags are sticky and are cleared by writing ones.

Top module: `irwake_matcher`

## Requirements
- R1: After reset, status, control, event enable, index, compare length, config2 and the cell counter all read 0, config1 reads 0x4A, and wake_o is low.
- R2: The index register (offset 0x8) holds the array select in bits 5:4 (01 = compare array, 10 = mask array) and the byte address in bits 3:0. An address above 10 is stored as 0. The register reads back as {2'b00, select, address}.
- R3: Each read or write of the data register (offset 0x9) with select 01 or 10 accesses the addressed byte of that array and then steps the address, from 10 back to 0. With select 00 or 11, writes are ignored, reads return 0 and the address does not move.
- R4: While control (offset 0x3) bit 0 is set, msg_start_i clears the capture and the cell counter. Each cell_valid_i stores cell_bit_i at the capture position equal to the number of earlier cells in the message, with the first cell at bit 0 of array byte 0. The counter reads at offset 0x6 (low byte) and 0x7 (high byte).
- R5: On msg_end_i, status (offset 0x4) bit 1 is set. Bit 0 is also set when every compared position satisfies (capture XOR compare) AND mask = 0. Both bits read back from the next cycle.
- R6: Status bits 0, 1, 2 and 4 are sticky. Writing 1 to a bit clears it, and writing 0 leaves it. Bits 3 and 7:5 read 0. A set in the same cycle as a clear wins.
- R7: A mask bit of 0 removes that position from the comparison.
- R8: When the compare length (offset 0xA) is N with 1 ≤ N ≤ 87, only capture bits below N are compared. When it is 0 or at least 88, all 88 bits are compared.
- R9: The capture is cleared when a message starts, so positions a short message does not reach compare as 0.
- R10: While control bit 0 is clear, msg_start_i, cell_valid_i, msg_end_i and rep_i have no effect on status, capture or counter.
- R11: wake_o is high exactly while some status bit k (k = 0, 1, 2) is set together with event-enable (offset 0x5) bit k. Status bit 4 never drives wake_o.
- R12: Cells after the 88th in a message are not stored. Each such cell sets status bit 2, while the counter keeps counting up to its maximum.
- R13: A pulse on rep_i sets status bit 4.
- R14: Config1 (offset 0xB) stores bits 6:0, and its bit 7 reads 0. Config2 (offset 0xC) stores all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (steps the data-port address) |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| msg_start_i | input | 1 | First-cell marker for a new message |
| cell_valid_i | input | 1 | A received cell is present |
| cell_bit_i | input | 1 | Value of the received cell |
| msg_end_i | input | 1 | End of the current message |
| rep_i | input | 1 | Repeat code seen by the front end |
| wake_o | output | 1 | Wake / interrupt request |

## Verification
The comparison is exercised with several kinds of message. An exact copy of the pattern must match. A copy with one flipped bit must fail, which shows that a message end alone does not set the match flag. The same flipped bit must match again once its mask bit is cleared, and a flip in a neighbouring bit must still fail, which confirms bit-exact mask placement. Messages that differ only above a programmed length must pass, while a flip just below that length must fail, and a length above 88 must behave like "all". A short message sent after a full one must fail, which shows that the capture is cleared. A 90-cell message separates storing from counting. A message sent with the receiver off must leave every flag and the counter untouched.

// File: rtl/irwake_pkg.sv
package irwake_pkg;
  localparam logic [3:0] OFS_CTL  = 4'h3;
  localparam logic [3:0] OFS_STS  = 4'h4;
  localparam logic [3:0] OFS_EVEN = 4'h5;
  localparam logic [3:0] OFS_CNTL = 4'h6;
  localparam logic [3:0] OFS_CNTH = 4'h7;
  localparam logic [3:0] OFS_IDX  = 4'h8;
  localparam logic [3:0] OFS_DATA = 4'h9;
  localparam logic [3:0] OFS_CLEN = 4'hA;
  localparam logic [3:0] OFS_CFG1 = 4'hB;
  localparam logic [3:0] OFS_CFG2 = 4'hC;

  localparam logic [6:0] CFG1_RST = 7'h4A;
  localparam logic [4:0] STS_IMPL = 5'b10111;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_CMP  = 2'b01,
    SEL_MSK  = 2'b10,
    SEL_RSV  = 2'b11
  } arr_sel_e;
endpackage

// File: rtl/irwake_capture.sv
module irwake_capture #(
  parameter int unsigned NBITS = 88,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_en_i,
  input  logic             msg_start_i,
  input  logic             cell_valid_i,
  input  logic             cell_bit_i,
  output logic [NBITS-1:0] cap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int unsigned PW = $clog2(NBITS + 1);

  logic [NBITS-1:0] cap_q;
  logic [PW-1:0]    pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_ev, cell_ev, room;

  assign start_ev = rx_en_i && msg_start_i;
  assign cell_ev  = rx_en_i && cell_valid_i && !msg_start_i;
  assign room     = pos_q < PW'(NBITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q <= '0;
      pos_q <= '0;
      cnt_q <= '0;
    end else if (start_ev) begin
      cap_q <= '0;
      pos_q <= '0;
      cnt_q <= '0;
    end else if (cell_ev) begin
      if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      if (room) begin
        cap_q[pos_q] <= cell_bit_i;
        pos_q        <= pos_q + 1'b1;
      end
    end
  end

  assign cap_o = cap_q;
  assign cnt_o = cnt_q;
  assign ovf_o = cell_ev && !room;

  AST_POS_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= PW'(NBITS)); // R12
  AST_OFF_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> ($stable(cnt_q) && $stable(cap_q))); // R10
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> (cnt_q == '0 && cap_q == '0)); // R9
endmodule

// File: rtl/irwake_compare.sv
module irwake_compare #(
  parameter int unsigned NBITS = 88,
  parameter int unsigned LW    = 8
) (
  input  logic [NBITS-1:0] cap_i,
  input  logic [NBITS-1:0] cmp_i,
  input  logic [NBITS-1:0] msk_i,
  input  logic [LW-1:0]    len_i,
  output logic             hit_o
);
  logic [NBITS-1:0] in_len;
  logic [NBITS-1:0] diff;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    assign in_len[i] = (len_i == '0) || (32'(i) < 32'(len_i));
    assign diff[i]   = (cap_i[i] ^ cmp_i[i]) & msk_i[i] & in_len[i];
  end

  assign hit_o = (diff == '0);
endmodule

// File: rtl/irwake_regs.sv
module irwake_regs
  import irwake_pkg::*;
#(
  parameter int unsigned NBYTES = 11,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned NBITS = NBYTES * 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             end_i,
  input  logic             hit_i,
  input  logic             ovf_i,
  input  logic             rep_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [NBITS-1:0] cmp_o,
  output logic [NBITS-1:0] msk_o,
  output logic [7:0]       len_o,
  output logic             rx_en_o,
  output logic             wake_o
);
  logic [7:0] cmp_q [NBYTES];
  logic [7:0] msk_q [NBYTES];
  logic [7:0] ctl_q, len_q, cfg2_q;
  logic [6:0] cfg1_q;
  logic [2:0] en_q;
  logic [4:0] sts_q;
  arr_sel_e   sel_q;
  logic [3:0] idx_q;

  logic       end_evt, rep_evt, data_acc, sts_wr;
  logic [4:0] sts_set, sts_clr;
  logic [7:0] data_rd;
  logic [15:0] cnt16;

  assign end_evt  = ctl_q[0] && end_i;
  assign rep_evt  = ctl_q[0] && rep_i;
  assign data_acc = (we_i || re_i) && addr_i == OFS_DATA &&
                    (sel_q == SEL_CMP || sel_q == SEL_MSK);
  assign sts_wr   = we_i && addr_i == OFS_STS;
  assign sts_set  = {rep_evt, 1'b0, ovf_i, end_evt, end_evt && hit_i};
  assign sts_clr  = sts_wr ? wdata_i[4:0] : 5'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q  <= '0;
      len_q  <= '0;
      cfg1_q <= CFG1_RST;
      cfg2_q <= '0;
      en_q   <= '0;
      sts_q  <= '0;
      sel_q  <= SEL_NONE;
      idx_q  <= '0;
      for (int k = 0; k < NBYTES; k++) begin
        cmp_q[k] <= '0;
        msk_q[k] <= '0;
      end
    end else begin
      sts_q <= ((sts_q & ~sts_clr) | sts_set) & STS_IMPL;
      if (we_i) begin
        unique case (addr_i)
          OFS_CTL:  ctl_q  <= wdata_i;
          OFS_EVEN: en_q   <= wdata_i[2:0];
          OFS_CLEN: len_q  <= wdata_i;
          OFS_CFG1: cfg1_q <= wdata_i[6:0];
          OFS_CFG2: cfg2_q <= wdata_i;
          OFS_IDX: begin
            sel_q <= arr_sel_e'(wdata_i[5:4]);
            idx_q <= (wdata_i[3:0] < 4'(NBYTES)) ? wdata_i[3:0] : 4'd0;
          end
          default: ;
        endcase
      end
      if (data_acc) begin
        if (we_i && sel_q == SEL_CMP) cmp_q[idx_q] <= wdata_i;
        if (we_i && sel_q == SEL_MSK) msk_q[idx_q] <= wdata_i;
        idx_q <= (idx_q == 4'(NBYTES - 1)) ? 4'd0 : idx_q + 4'd1;
      end
    end
  end

  always_comb begin
    unique case (sel_q)
      SEL_CMP: data_rd = cmp_q[idx_q];
      SEL_MSK: data_rd = msk_q[idx_q];
      default: data_rd = 8'h00;
    endcase
  end

  assign cnt16 = 16'(cnt_i);

  always_comb begin
    unique case (addr_i)
      OFS_CTL:  rdata_o = ctl_q;
      OFS_STS:  rdata_o = {3'b000, sts_q};
      OFS_EVEN: rdata_o = {5'b00000, en_q};
      OFS_CNTL: rdata_o = cnt16[7:0];
      OFS_CNTH: rdata_o = cnt16[15:8];
      OFS_IDX:  rdata_o = {2'b00, sel_q, idx_q};
      OFS_DATA: rdata_o = data_rd;
      OFS_CLEN: rdata_o = len_q;
      OFS_CFG1: rdata_o = {1'b0, cfg1_q};
      OFS_CFG2: rdata_o = cfg2_q;
      default:  rdata_o = 8'h00;
    endcase
  end

  for (genvar k = 0; k < NBYTES; k++) begin : g_flat
    assign cmp_o[k*8 +: 8] = cmp_q[k];
    assign msk_o[k*8 +: 8] = msk_q[k];
  end

  assign len_o   = len_q;
  assign rx_en_o = ctl_q[0];
  assign wake_o  = |(sts_q[2:0] & en_q);

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q < 4'(NBYTES)); // R3
  AST_MATCH_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q[0]) |-> $past(end_evt && hit_i)); // R5
  AST_W1C_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_wr && wdata_i[1] && !end_evt) |=> !sts_q[1]); // R6
  AST_WAKE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(end_evt || ovf_i || (we_i && addr_i == OFS_EVEN))); // R11
  AST_OFF_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[0] && !sts_wr) |=> $stable(sts_q)); // R10
endmodule

// File: rtl/irwake_matcher.sv
module irwake_matcher #(
  parameter int unsigned NBYTES = 11,
  parameter int unsigned CNT_W  = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic       reg_re_i,
  input  logic [3:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       msg_start_i,
  input  logic       cell_valid_i,
  input  logic       cell_bit_i,
  input  logic       msg_end_i,
  input  logic       rep_i,
  output logic       wake_o
);
  localparam int unsigned NBITS = NBYTES * 8;

  logic [NBITS-1:0] cap, cmp, msk;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       len;
  logic             rx_en, ovf, hit;

  irwake_regs #(.NBYTES(NBYTES), .CNT_W(CNT_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .re_i    (reg_re_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .end_i   (msg_end_i),
    .hit_i   (hit),
    .ovf_i   (ovf),
    .rep_i   (rep_i),
    .cnt_i   (cnt),
    .cmp_o   (cmp),
    .msk_o   (msk),
    .len_o   (len),
    .rx_en_o (rx_en),
    .wake_o  (wake_o)
  );

  irwake_capture #(.NBITS(NBITS), .CNT_W(CNT_W)) u_cap (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rx_en_i      (rx_en),
    .msg_start_i  (msg_start_i),
    .cell_valid_i (cell_valid_i),
    .cell_bit_i   (cell_bit_i),
    .cap_o        (cap),
    .cnt_o        (cnt),
    .ovf_o        (ovf)
  );

  irwake_compare #(.NBITS(NBITS), .LW(8)) u_cmp (
    .cap_i (cap),
    .cmp_i (cmp),
    .msk_i (msk),
    .len_i (len),
    .hit_o (hit)
  );
endmodule

// File: tb/irwake_matcher_test.sv
module irwake_matcher_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       mstart = 1'b0, cvalid = 1'b0, cbit = 1'b0, mend = 1'b0, rep = 1'b0;
  logic       wake;
  int         checks = 0, failures = 0;
  bit         done = 1'b0;

  localparam logic [87:0] PAT = 88'hA5_3C_0F_F0_96_69_12_34_56_78_9B;

  always #2 clk = ~clk;

  irwake_matcher uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_re_i(re),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .msg_start_i(mstart), .cell_valid_i(cvalid), .cell_bit_i(cbit),
    .msg_end_i(mend), .rep_i(rep), .wake_o(wake)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); re = 1'b1; addr = a; #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic send(logic [95:0] b, int n);
    @(negedge clk); mstart = 1'b1;
    @(negedge clk); mstart = 1'b0;
    for (int i = 0; i < n; i++) begin
      cvalid = 1'b1; cbit = b[i];
      @(negedge clk);
    end
    cvalid = 1'b0; mend = 1'b1;
    @(negedge clk); mend = 1'b0;
  endtask

  task automatic expect_sts(string req, logic [7:0] exp);
    logic [7:0] v;
    rd(4'h4, v);
    chk(req, v, exp);
    wr(4'h4, 8'hFF);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 wake", wake, 0);
    rd(4'h4, v); chk("R1 status", v, 8'h00);
    rd(4'h3, v); chk("R1 ctl", v, 8'h00);
    rd(4'h8, v); chk("R1 index", v, 8'h00);
    rd(4'hB, v); chk("R1 cfg1", v, 8'h4A);
    rd(4'h6, v); chk("R1 cnt", v, 8'h00);
  endtask

  task automatic t_load;
    logic [7:0] v;
    wr(4'h8, 8'h10);
    for (int k = 0; k < 11; k++) wr(4'h9, PAT[k*8 +: 8]);
    rd(4'h8, v); chk("R3 wrap", v, 8'h10);
    wr(4'h8, 8'h20);
    for (int k = 0; k < 11; k++) wr(4'h9, 8'hFF);
    wr(4'h8, 8'h13);
    rd(4'h9, v); chk("R3 cmp byte3", v, PAT[31:24]);
    rd(4'h8, v); chk("R2 index step", v, 8'h14);
    wr(4'h8, 8'h2A);
    rd(4'h9, v); chk("R3 msk byte10", v, 8'hFF);
    wr(4'h8, 8'h1C);
    rd(4'h8, v); chk("R2 addr clamp", v, 8'h10);
    wr(4'h8, 8'h05);
    wr(4'h9, 8'h77);
    rd(4'h9, v); chk("R3 no-select read", v, 8'h00);
    rd(4'h8, v); chk("R3 no-select hold", v, 8'h05);
    wr(4'h8, 8'h10);
    rd(4'h9, v); chk("R3 no-select write ignored", v, PAT[7:0]);
  endtask

  task automatic t_match;
    logic [7:0] v;
    wr(4'h3, 8'h01); wr(4'h5, 8'h01); wr(4'hA, 8'h00);
    send({8'h0, PAT}, 88);
    chk("R11 wake on match", wake, 1);
    rd(4'h6, v); chk("R4 count", v, 8'd88);
    rd(4'h4, v); chk("R5 match+end", v, 8'h03);
    wr(4'h4, 8'h01);
    rd(4'h4, v); chk("R6 partial clear", v, 8'h02);
    chk("R11 wake after clear", wake, 0);
    wr(4'h4, 8'h02);
    rd(4'h4, v); chk("R6 cleared", v, 8'h00);
    send({8'h0, PAT ^ 88'h20}, 88);
    chk("R11 end not enabled", wake, 0);
    expect_sts("R5 mismatch", 8'h02);
  endtask

  task automatic t_mask;
    wr(4'h8, 8'h20); wr(4'h9, 8'hDF);
    send({8'h0, PAT ^ 88'h20}, 88);
    expect_sts("R7 masked bit", 8'h03);
    send({8'h0, PAT ^ 88'h40}, 88);
    expect_sts("R7 neighbour bit", 8'h02);
    wr(4'h8, 8'h20); wr(4'h9, 8'hFF);
  endtask

  task automatic t_len;
    logic [87:0] hi_flip;
    hi_flip = {72'hFF_FFFF_FFFF_FFFF_FFFF, 16'h0};
    wr(4'hA, 8'd16);
    send({8'h0, PAT ^ hi_flip}, 88);
    expect_sts("R8 beyond length", 8'h03);
    send({8'h0, PAT ^ 88'h8000}, 88);
    expect_sts("R8 last compared bit", 8'h02);
    wr(4'hA, 8'd100);
    send({8'h0, PAT ^ (88'h1 << 87)}, 88);
    expect_sts("R8 length over 88", 8'h02);
  endtask

  task automatic t_short;
    wr(4'hA, 8'd0);
    send({8'h0, PAT}, 88);
    expect_sts("R9 full first", 8'h03);
    send({88'h0, PAT[7:0]}, 8);
    expect_sts("R9 capture cleared", 8'h02);
    wr(4'hA, 8'd8);
    send({88'h0, PAT[7:0]}, 8);
    expect_sts("R8 short with length", 8'h03);
    wr(4'hA, 8'd0);
  endtask

  task automatic t_overflow;
    logic [7:0] v;
    wr(4'h5, 8'h04);
    send({8'h3, PAT}, 90);
    chk("R11 wake on buffer", wake, 1);
    rd(4'h6, v); chk("R12 count low", v, 8'd90);
    rd(4'h7, v); chk("R12 count high", v, 8'd0);
    expect_sts("R12 buffer flag, first 88 match", 8'h07);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    wr(4'h3, 8'h00);
    send({8'h0, PAT}, 20);
    @(negedge clk); rep = 1'b1; @(negedge clk); rep = 1'b0;
    rd(4'h4, v); chk("R10 no flags", v, 8'h00);
    rd(4'h6, v); chk("R10 counter held", v, 8'd90);
    wr(4'h3, 8'h01);
  endtask

  task automatic t_rep_wake;
    logic [7:0] v;
    wr(4'h5, 8'h07);
    @(negedge clk); rep = 1'b1; @(negedge clk); rep = 1'b0;
    rd(4'h4, v); chk("R13 repeat flag", v, 8'h10);
    chk("R11 repeat no wake", wake, 0);
    wr(4'h4, 8'h10);
    rd(4'h4, v); chk("R6 repeat clear", v, 8'h00);
    wr(4'h5, 8'h00);
    send({8'h0, PAT}, 88);
    chk("R11 disabled events", wake, 0);
    wr(4'h5, 8'h02);
    chk("R11 late enable", wake, 1);
    wr(4'h4, 8'h02);
    chk("R11 end cleared", wake, 0);
    wr(4'h4, 8'h01);
  endtask

  task automatic t_cfg;
    logic [7:0] v;
    wr(4'hB, 8'hFF);
    rd(4'hB, v); chk("R14 cfg1", v, 8'h7F);
    wr(4'hC, 8'h5C);
    rd(4'hC, v); chk("R14 cfg2", v, 8'h5C);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_load();
    t_match();
    t_mask();
    t_len();
    t_short();
    t_overflow();
    t_disabled();
    t_rep_wake();
    t_cfg();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule